// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block is the interrupt status and enable logic of a network controller. It keeps five sticky event flags: receive done, transmit done, initialization done, memory error and system interrupt. Each flag is set by a one-cycle pulse from the datapath and stays set until the host writes a 1 to its bit. A second register holds one mask bit per source. The block also holds two qualifier controls. One stops successful transmissions from raising transmit done. The other lets the release of a frame's first receive descriptor raise receive done.

From the unmasked flags the block derives a read-only summary flag. It drives an active-low, registered interrupt pin. The pin is gated by a global enable bit, except for the system-interrupt source, which bypasses that gate. A hard reset, a soft reset or a stop command clears all flags and the enable. The mask and the qualifier controls are cleared only by hard reset. The host reaches both registers through a simple single-cycle write port and a combinational read port.

Top module: `irq_status_ctrl`

## Requirements
- R1: The flags sit in the status register (address 0) at bits 0 receive, 1 transmit, 2 init, 3 memory error, 4 system. An event pulse sets its flag at the next clock. A write of 1 to a flag bit clears it, and a write of 0 leaves it unchanged.
- R2: If a write of 1 to a flag bit and a new event for that flag arrive in the same cycle, the flag is set after the edge.
- R3: `rst_n` low clears flags, global enable, mask and qualifier controls, and drives `irq_n` high. A cycle with `soft_rst` or `stop_cmd` high clears the flags and the global enable at the next edge. It leaves the mask register unchanged.
- R4: The mask register (address 1) holds the mask bits at 0..4, in the same order as the flags. Status bit 5 is the summary: the OR of all set flags whose mask bit is 0. Writes to bit 5 have no effect.
- R5: `irq_n` is low one clock after the summary is 1 while the global enable is 1. It returns high one clock after that condition ends. With the global enable 0, `irq_n` stays high unless R6 applies.
- R6: A set, unmasked system flag drives `irq_n` low one clock later, whatever the global enable holds.
- R7: Status bit 6 is the global enable. Each write to address 0 loads it from write data bit 6.
- R8: Status bit 7 is an error indication. It reads 1 whenever the memory-error flag is set, whatever its mask bit or the global enable holds.
- R9: When mask-register bit 8 is 1, a transmit-done pulse with `ev_tx_ok` high does not set the transmit flag. A pulse with `ev_tx_ok` low still sets it. When bit 8 is 0, every transmit-done pulse sets it.
- R10: A last-descriptor pulse always sets the receive flag. A first-descriptor pulse sets it only when mask-register bit 9 (look-ahead) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset |
| stop_cmd | input | 1 | Stop command, clears flags and enable |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 status, 1 mask/control) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| ev_rx_last | input | 1 | Last receive descriptor released |
| ev_rx_first | input | 1 | First receive descriptor released |
| ev_tx_done | input | 1 | Transmit frame finished |
| ev_tx_ok | input | 1 | Qualifier: the finished transmission succeeded |
| ev_init_done | input | 1 | Initialization finished |
| ev_mem_err | input | 1 | Memory error |
| ev_sys | input | 1 | System interrupt event |
| irq_n | output | 1 | Registered host interrupt pin, active low |

## Verification
Two functions can meet in one cycle: a host write-1-to-clear of a flag and a new event pulse for the same flag. The bench provokes this once on purpose. It holds the write strobe and the receive event high together for a single cycle, with the flag already set, and expects the flag to read back set afterwards. A randomized phase then drives writes with random data alongside random event pulses, soft resets and stop commands, so these collisions recur on every source. A behavioural model judges every cycle against the read port and the pin.

// File: rtl/irq_pkg.sv
package irq_pkg;
   // Source slots in the flag and mask vectors
   localparam int unsigned NUM_SRC   = 5;
   localparam int unsigned SRC_RX    = 0;
   localparam int unsigned SRC_TX    = 1;
   localparam int unsigned SRC_INIT  = 2;
   localparam int unsigned SRC_MERR  = 3;
   localparam int unsigned SRC_SYS   = 4;
   // Status register extra bits
   localparam int unsigned STAT_SUM_BIT = 5;
   localparam int unsigned STAT_EN_BIT  = 6;
   localparam int unsigned STAT_ERR_BIT = 7;
   // Mask/control register extra bits
   localparam int unsigned CTL_TXSUP_BIT = 8;
   localparam int unsigned CTL_LA_BIT    = 9;
endpackage

// File: rtl/irq_event_qual.sv
module irq_event_qual
   import irq_pkg::*;
(
   input  logic               rx_last,
   input  logic               rx_first,
   input  logic               tx_done,
   input  logic               tx_ok,
   input  logic               init_done,
   input  logic               mem_err,
   input  logic               sys_ev,
   input  logic               tx_ok_suppress,
   input  logic               lookahead_en,
   output logic [NUM_SRC-1:0] ev_vec
);
   always_comb begin
      ev_vec           = '0;
      ev_vec[SRC_RX]   = rx_last | (rx_first & lookahead_en);
      ev_vec[SRC_TX]   = tx_done & ~(tx_ok & tx_ok_suppress);
      ev_vec[SRC_INIT] = init_done;
      ev_vec[SRC_MERR] = mem_err;
      ev_vec[SRC_SYS]  = sys_ev;
   end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int unsigned N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_all,
   input  logic [N-1:0] ev_vec,
   input  logic [N-1:0] w1c_vec,
   output logic [N-1:0] flags
);
   initial begin : p_param_check
      assert (N >= 1) else $error("irq_flag_bank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          q <= 1'b0;
         else if (clr_all)    q <= 1'b0;
         else if (ev_vec[i])  q <= 1'b1;   // event beats a same-cycle clear
         else if (w1c_vec[i]) q <= 1'b0;
      end
      assign flags[i] = q;
   end
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
   parameter int unsigned N       = 5,
   parameter int unsigned SYS_IDX = 4,
   parameter bit          PIN_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] flags,
   input  logic [N-1:0] mask,
   input  logic         enable,
   output logic         summary,
   output logic         irq_n
);
   logic [N-1:0] live;
   logic         want_irq;

   initial begin : p_param_check
      assert (SYS_IDX < N) else $error("irq_pin_drv: SYS_IDX out of range");
   end

   assign live     = flags & ~mask;
   assign summary  = |live;
   assign want_irq = (summary & enable) | live[SYS_IDX];

   if (PIN_REG) begin : g_reg_pin
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_n <= 1'b1;
         else        irq_n <= ~want_irq;
      end
   end else begin : g_comb_pin
      assign irq_n = ~want_irq;
   end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
   import irq_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned STATUS_ADDR = 0,
   parameter int unsigned MASK_ADDR   = 1,
   parameter bit          PIN_REG     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              stop_cmd,
   input  logic              reg_wr_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              ev_rx_last,
   input  logic              ev_rx_first,
   input  logic              ev_tx_done,
   input  logic              ev_tx_ok,
   input  logic              ev_init_done,
   input  logic              ev_mem_err,
   input  logic              ev_sys,
   output logic              irq_n
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STATUS_ADDR);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);

   initial begin : p_param_check
      assert (DATA_W > CTL_LA_BIT) else $error("irq_status_ctrl: DATA_W too narrow");
      assert (STATUS_ADDR != MASK_ADDR) else $error("irq_status_ctrl: address clash");
      assert (MASK_ADDR < (1 << ADDR_W) && STATUS_ADDR < (1 << ADDR_W))
         else $error("irq_status_ctrl: address exceeds ADDR_W");
   end

   logic               clr_all;
   logic               wr_stat;
   logic               wr_mask;
   logic [NUM_SRC-1:0] w1c_vec;
   logic [NUM_SRC-1:0] ev_vec;
   logic [NUM_SRC-1:0] flags_q;
   logic [NUM_SRC-1:0] mask_q;
   logic               enable_q;
   logic               tx_sup_q;
   logic               la_q;
   logic               summary;
   logic               unused_wdata;

   assign clr_all      = soft_rst | stop_cmd;
   assign wr_stat      = reg_wr_en && (reg_addr == A_STAT);
   assign wr_mask      = reg_wr_en && (reg_addr == A_MASK);
   assign w1c_vec      = wr_stat ? reg_wdata[NUM_SRC-1:0] : '0;
   assign unused_wdata = ^reg_wdata;

   // Global enable: loaded by every status write, dropped by soft reset or stop
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       enable_q <= 1'b0;
      else if (clr_all) enable_q <= 1'b0;
      else if (wr_stat) enable_q <= reg_wdata[STAT_EN_BIT];
   end

   // Mask and qualifier controls: hard reset only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q   <= '0;
         tx_sup_q <= 1'b0;
         la_q     <= 1'b0;
      end else if (wr_mask) begin
         mask_q   <= reg_wdata[NUM_SRC-1:0];
         tx_sup_q <= reg_wdata[CTL_TXSUP_BIT];
         la_q     <= reg_wdata[CTL_LA_BIT];
      end
   end

   irq_event_qual u_qual (
      .rx_last       (ev_rx_last),
      .rx_first      (ev_rx_first),
      .tx_done       (ev_tx_done),
      .tx_ok         (ev_tx_ok),
      .init_done     (ev_init_done),
      .mem_err       (ev_mem_err),
      .sys_ev        (ev_sys),
      .tx_ok_suppress(tx_sup_q),
      .lookahead_en  (la_q),
      .ev_vec        (ev_vec)
   );

   irq_flag_bank #(.N(NUM_SRC)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_all(clr_all),
      .ev_vec (ev_vec),
      .w1c_vec(w1c_vec),
      .flags  (flags_q)
   );

   irq_pin_drv #(.N(NUM_SRC), .SYS_IDX(SRC_SYS), .PIN_REG(PIN_REG)) u_pin (
      .clk    (clk),
      .rst_n  (rst_n),
      .flags  (flags_q),
      .mask   (mask_q),
      .enable (enable_q),
      .summary(summary),
      .irq_n  (irq_n)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_STAT) begin
         reg_rdata[NUM_SRC-1:0]  = flags_q;
         reg_rdata[STAT_SUM_BIT] = summary;
         reg_rdata[STAT_EN_BIT]  = enable_q;
         reg_rdata[STAT_ERR_BIT] = flags_q[SRC_MERR];
      end else if (reg_addr == A_MASK) begin
         reg_rdata[NUM_SRC-1:0]   = mask_q;
         reg_rdata[CTL_TXSUP_BIT] = tx_sup_q;
         reg_rdata[CTL_LA_BIT]    = la_q;
      end
   end
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk
   import irq_pkg::*;
#(
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned STATUS_ADDR = 0,
   parameter bit          PIN_REG     = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               soft_rst,
   input logic               stop_cmd,
   input logic               reg_wr_en,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [NUM_SRC-1:0] wdata_lo,
   input logic               ev_tx_done,
   input logic               ev_tx_ok,
   input logic               ev_rx_first,
   input logic               ev_rx_last,
   input logic               ev_mem_err,
   input logic [NUM_SRC-1:0] ev_vec,
   input logic [NUM_SRC-1:0] flags,
   input logic               mask_sys,
   input logic               enable_q,
   input logic               tx_sup_q,
   input logic               la_q,
   input logic               irq_n
);
   logic [NUM_SRC-1:0] w1c;
   logic               quiet;
   assign w1c   = (reg_wr_en && reg_addr == ADDR_W'(STATUS_ADDR)) ? wdata_lo : '0;
   assign quiet = !soft_rst && !stop_cmd;

   // R1: a set flag not written with 1 stays set
   a_r1_hold_unless_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      quiet |=> ((flags & $past(flags & ~w1c)) == $past(flags & ~w1c)));

   // R2: a qualified event always leaves its flag set, even against a clear
   a_r2_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      quiet |=> ((flags & $past(ev_vec)) == $past(ev_vec)));

   // R3: soft reset and stop clear flags and enable
   a_r3_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst || stop_cmd) |=> (flags == '0 && !enable_q));

   // R8: memory error sets its flag regardless of mask or enable
   a_r8_merr_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && ev_mem_err) |=> flags[SRC_MERR]);

   // R9: suppressed successful transmission leaves a clear flag clear
   a_r9_tx_ok_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[SRC_TX] && ev_tx_done && ev_tx_ok && tx_sup_q) |=> !flags[SRC_TX]);

   // R10: first-descriptor release is ignored without look-ahead
   a_r10_first_needs_la: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[SRC_RX] && ev_rx_first && !ev_rx_last && !la_q) |=> !flags[SRC_RX]);

   if (PIN_REG) begin : g_pin_props
      // R5: pin stays high with enable low and no live system flag
      a_r5_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
         (!enable_q && !(flags[SRC_SYS] && !mask_sys)) |=> irq_n);
      // R6: live system flag drives the pin low regardless of enable
      a_r6_sys_bypass: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[SRC_SYS] && !mask_sys) |=> !irq_n);
   end
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(
   .ADDR_W     (ADDR_W),
   .STATUS_ADDR(STATUS_ADDR),
   .PIN_REG    (PIN_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .soft_rst   (soft_rst),
   .stop_cmd   (stop_cmd),
   .reg_wr_en  (reg_wr_en),
   .reg_addr   (reg_addr),
   .wdata_lo   (reg_wdata[4:0]),
   .ev_tx_done (ev_tx_done),
   .ev_tx_ok   (ev_tx_ok),
   .ev_rx_first(ev_rx_first),
   .ev_rx_last (ev_rx_last),
   .ev_mem_err (ev_mem_err),
   .ev_vec     (ev_vec),
   .flags      (flags_q),
   .mask_sys   (mask_q[4]),
   .enable_q   (enable_q),
   .tx_sup_q   (tx_sup_q),
   .la_q       (la_q),
   .irq_n      (irq_n)
);

// File: tb/irq_status_ctrl_tb.sv
`timescale 1ns/1ps
module irq_status_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0, stop_cmd = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [15:0] reg_wdata = 16'h0;
   logic [15:0] reg_rdata;
   logic        ev_rx_last = 1'b0, ev_rx_first = 1'b0, ev_tx_done = 1'b0, ev_tx_ok = 1'b0;
   logic        ev_init_done = 1'b0, ev_mem_err = 1'b0, ev_sys = 1'b0;
   logic        irq_n;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   bit cmp_on = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   irq_status_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop_cmd(stop_cmd),
      .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .ev_rx_last(ev_rx_last), .ev_rx_first(ev_rx_first),
      .ev_tx_done(ev_tx_done), .ev_tx_ok(ev_tx_ok), .ev_init_done(ev_init_done),
      .ev_mem_err(ev_mem_err), .ev_sys(ev_sys), .irq_n(irq_n)
   );

   // ---------------- behavioural reference model ----------------
   bit [4:0] m_flags, m_mask;
   bit       m_en, m_sup, m_la, m_pin;

   always @(posedge clk or negedge rst_n) begin : model
      bit [4:0] ev;
      bit [4:0] live;
      bit       req;
      if (!rst_n) begin
         m_flags = '0; m_mask = '0; m_en = 0; m_sup = 0; m_la = 0; m_pin = 1;
      end else begin
         live  = m_flags & ~m_mask;
         req   = ((live != 0) && m_en) || live[4];
         ev[0] = ev_rx_last || (ev_rx_first && m_la);
         ev[1] = ev_tx_done && !(ev_tx_ok && m_sup);
         ev[2] = ev_init_done;
         ev[3] = ev_mem_err;
         ev[4] = ev_sys;
         if (soft_rst || stop_cmd) begin
            m_flags = '0;
            m_en    = 0;
         end else begin
            if (reg_wr_en && reg_addr == 2'd0) begin
               m_flags = m_flags & ~reg_wdata[4:0];
               m_en    = reg_wdata[6];
            end
            m_flags = m_flags | ev;
         end
         if (reg_wr_en && reg_addr == 2'd1) begin
            m_mask = reg_wdata[4:0];
            m_sup  = reg_wdata[8];
            m_la   = reg_wdata[9];
         end
         m_pin = !req;
      end
   end

   function automatic logic [15:0] model_rd(input logic [1:0] a);
      case (a)
         2'd0:    return {8'h00, m_flags[3], m_en, (m_flags & ~m_mask) != 0, m_flags};
         2'd1:    return {6'h00, m_la, m_sup, 3'b000, m_mask};
         default: return 16'h0000;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // per-clock comparison, sampled mid-cycle
   always @(negedge clk) begin
      if (cmp_on && !done) begin
         chk(reg_rdata == model_rd(reg_addr), "R1 model readback", reg_rdata, model_rd(reg_addr));
         chk(irq_n == m_pin, "R5 model pin", irq_n, m_pin);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wreg(input logic [1:0] a, input logic [15:0] d);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      tick();
      reg_wr_en = 1'b0; reg_wdata = 16'h0;
   endtask

   task automatic expect_rd(input logic [1:0] a, input int exp, input string tag);
      reg_addr = a;
      @(negedge clk);
      chk(reg_rdata == exp[15:0], tag, reg_rdata, exp);
   endtask

   task automatic expect_pin(input bit exp, input string tag);
      @(negedge clk);
      chk(irq_n == exp, tag, irq_n, exp);
   endtask

   initial begin : watchdog
      #(4 * 100000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) tick();
      rst_n = 1'b1;
      cmp_on = 1'b1;
      tick();

      // R3 reset state
      expect_rd(2'd0, 16'h0000, "R3 status after reset");
      chk(irq_n == 1'b1, "R3 pin after reset", irq_n, 1);
      expect_rd(2'd1, 16'h0000, "R3 mask after reset");

      // R7 enable write
      wreg(2'd0, 16'h0040);
      expect_rd(2'd0, 16'h0040, "R7 enable set");

      // R1 set, R5 latency
      ev_rx_last = 1'b1; tick(); ev_rx_last = 1'b0;
      expect_rd(2'd0, 16'h0061, "R1 rx flag set");
      chk(irq_n == 1'b1, "R5 pin one cycle late", irq_n, 1);
      expect_pin(1'b0, "R5 pin asserted");

      // R1 write 0 keeps, write 1 clears
      wreg(2'd0, 16'h0040);
      expect_rd(2'd0, 16'h0061, "R1 write 0 no effect");
      wreg(2'd0, 16'h0041);
      expect_rd(2'd0, 16'h0040, "R1 write 1 clears");
      chk(irq_n == 1'b0, "R5 pin holds one cycle", irq_n, 0);
      expect_pin(1'b1, "R5 pin released");

      // R4 mask and read-only summary
      wreg(2'd1, 16'h0001);
      ev_rx_last = 1'b1; tick(); ev_rx_last = 1'b0;
      expect_rd(2'd0, 16'h0041, "R4 masked flag no summary");
      expect_pin(1'b1, "R4 masked pin idle");
      wreg(2'd0, 16'h0060);
      expect_rd(2'd0, 16'h0041, "R4 summary write ignored");
      wreg(2'd1, 16'h0000);
      expect_rd(2'd0, 16'h0061, "R4 unmasked summary");

      // R5 enable off
      wreg(2'd0, 16'h0000);
      expect_rd(2'd0, 16'h0021, "R7 enable cleared");
      expect_pin(1'b1, "R5 enable off pin high");

      // R6 system bypass
      ev_sys = 1'b1; tick(); ev_sys = 1'b0;
      expect_rd(2'd0, 16'h0031, "R6 sys flag");
      expect_pin(1'b0, "R6 bypass pin low");
      wreg(2'd1, 16'h0010);
      @(negedge clk);
      expect_pin(1'b1, "R6 masked sys pin high");
      wreg(2'd0, 16'h001F);
      wreg(2'd1, 16'h0000);

      // R8 error bit despite mask
      wreg(2'd1, 16'h0008);
      ev_mem_err = 1'b1; tick(); ev_mem_err = 1'b0;
      expect_rd(2'd0, 16'h0088, "R8 error bit with mask");
      wreg(2'd0, 16'h0008);
      expect_rd(2'd0, 16'h0000, "R8 error bit cleared");
      wreg(2'd1, 16'h0000);

      // R2 clear and event together
      ev_rx_last = 1'b1; tick(); ev_rx_last = 1'b0;
      reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0001; ev_rx_last = 1'b1;
      tick();
      reg_wr_en = 1'b0; reg_wdata = 16'h0; ev_rx_last = 1'b0;
      expect_rd(2'd0, 16'h0021, "R2 event beats clear");
      wreg(2'd0, 16'h0001);

      // R9 transmit-OK suppression
      wreg(2'd1, 16'h0100);
      ev_tx_done = 1'b1; ev_tx_ok = 1'b1; tick(); ev_tx_done = 1'b0; ev_tx_ok = 1'b0;
      expect_rd(2'd0, 16'h0000, "R9 ok suppressed");
      ev_tx_done = 1'b1; tick(); ev_tx_done = 1'b0;
      expect_rd(2'd0, 16'h0022, "R9 failed tx still sets");
      wreg(2'd0, 16'h0002);
      wreg(2'd1, 16'h0000);
      ev_tx_done = 1'b1; ev_tx_ok = 1'b1; tick(); ev_tx_done = 1'b0; ev_tx_ok = 1'b0;
      expect_rd(2'd0, 16'h0022, "R9 ok sets when not suppressed");
      wreg(2'd0, 16'h0002);

      // R10 look-ahead
      ev_rx_first = 1'b1; tick(); ev_rx_first = 1'b0;
      expect_rd(2'd0, 16'h0000, "R10 first ignored without look-ahead");
      wreg(2'd1, 16'h0200);
      ev_rx_first = 1'b1; tick(); ev_rx_first = 1'b0;
      expect_rd(2'd0, 16'h0021, "R10 first sets with look-ahead");
      wreg(2'd0, 16'h0001);
      wreg(2'd1, 16'h0000);

      // R3 soft reset, stop, hard reset
      wreg(2'd1, 16'h0004);
      wreg(2'd0, 16'h0040);
      ev_init_done = 1'b1; tick(); ev_init_done = 1'b0;
      soft_rst = 1'b1; tick(); soft_rst = 1'b0;
      expect_rd(2'd0, 16'h0000, "R3 soft reset clears");
      expect_rd(2'd1, 16'h0004, "R3 soft reset keeps mask");
      tick();
      wreg(2'd0, 16'h0040);
      ev_rx_last = 1'b1; tick(); ev_rx_last = 1'b0;
      stop_cmd = 1'b1; tick(); stop_cmd = 1'b0;
      expect_rd(2'd0, 16'h0000, "R3 stop clears");
      tick();
      rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
      expect_rd(2'd1, 16'h0000, "R3 hard reset clears mask");
      chk(irq_n == 1'b1, "R3 pin after hard reset", irq_n, 1);

      // randomized phase, judged by the per-clock model comparison
      for (int i = 0; i < 2000; i++) begin
         reg_wr_en    = ($urandom % 4) == 0;
         reg_addr     = 2'($urandom % 4);
         reg_wdata    = 16'($urandom);
         ev_rx_last   = ($urandom % 5) == 0;
         ev_rx_first  = ($urandom % 5) == 0;
         ev_tx_done   = ($urandom % 5) == 0;
         ev_tx_ok     = ($urandom % 2) == 0;
         ev_init_done = ($urandom % 7) == 0;
         ev_mem_err   = ($urandom % 7) == 0;
         ev_sys       = ($urandom % 9) == 0;
         soft_rst     = ($urandom % 40) == 0;
         stop_cmd     = ($urandom % 40) == 0;
         tick();
      end
      reg_wr_en = 0; ev_rx_last = 0; ev_rx_first = 0; ev_tx_done = 0; ev_tx_ok = 0;
      ev_init_done = 0; ev_mem_err = 0; ev_sys = 0; soft_rst = 0; stop_cmd = 0;
      repeat (3) tick();
      @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule